// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block drives one 10-bit successive-approximation conversion at a time. A start strobe latches a 4-bit timing setting. The block then runs three phases in a fixed order. First comes a sample phase, during which the sample-enable output is high. Next come ten bit trials, which present trial codes to an external DAC and read back a comparator decision. Last comes an extra phase that transfers the resolved code into the result register. The analog capacitor array, the reference and the input selection are outside this block. The comparator reaches it as a single digital input.

Durations are set in half-clock units, so two units equal one system clock. The sample time and the per-bit comparison time each come from their own 2-bit field. Slower settings suit sources with high internal resistance. The fastest settings suit signals with high-frequency content.

Top module: `adcSeq`

## Requirements
- R1: While the active-high synchronous reset is asserted, and in the first cycle after it is released, busy, sampleEn, done, trialCode and result are all zero.
- R2: cfgIn[1:0] is the sample field s and cfgIn[3:2] is the conversion field c. For every setting other than s=01 with c=00, the sample phase lasts 60<<s clocks (120<<s half-clock units). Each bit trial lasts 12<<c clocks, and the extra phase lasts 14 clocks.
- R3: busy rises in the cycle after an accepted start. It stays high for exactly the sum of the sample, ten bit-trial and extra durations, so with cfgIn=0000 a conversion takes 194 clocks (388 half-clock units).
- R4: The setting c=00, s=01 is special. Its sample phase lasts 70 clocks, each bit trial lasts 14 clocks, and the extra phase lasts 8 clocks, for 218 clocks (436 half-clock units) in total.
- R5: Bits are tried from bit 9 down to bit 0. The first trial code of every conversion is 10'h200. trialCode is nonzero only during the comparison phase, and it is nonzero in every cycle of that phase.
- R6: On the last cycle of each bit trial, the bit under test is kept if compIn is high and cleared if it is low. An ideal comparator that is high when trialCode <= vin therefore yields result == vin.
- R7: The timing setting is sampled only when a start is accepted. A start or a cfgIn change during busy has no effect on the running conversion's timing or result.
- R8: result changes only at the end of the extra phase. done is high for exactly one cycle at that moment, the same cycle in which busy has just fallen.
- R9: result holds the last completed value throughout the following conversion until that conversion's done.
- R10: sampleEn is high only during the sample phase, for exactly the sample duration, and never while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high synchronous reset |
| startIn | input | 1 | Start strobe, accepted only when idle |
| cfgIn | input | 4 | Timing setting: [3:2] conversion field, [1:0] sample field |
| compIn | input | 1 | Comparator decision for the current trial code |
| sampleEn | output | 1 | High during the sample phase |
| trialCode | output | 10 | Trial code presented to the DAC during comparison |
| busy | output | 1 | Conversion in progress |
| result | output | 10 | Last completed conversion result |
| done | output | 1 | One-cycle pulse when result updates |

## Verification
The assertions assume the reset is applied from time zero. They also assume compIn is a settled digital level at each rising edge; its value outside the comparison phase does not matter. The bench drives compIn combinationally from trialCode through an ideal comparison against a chosen input value, so it is always settled before the edge. The bench changes startIn and cfgIn only on falling edges. Each conversion is launched from idle, and later starts are deliberately issued in the middle of a busy period.

// File: rtl/adcSeqPkg.sv
package adcSeqPkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_COMPARE,
    ST_EXTRA
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearSar;  // accepted start: reset SAR and point mask at MSB
    logic decide;    // last cycle of a bit trial: keep or drop the bit
    logic commit;    // last cycle of the extra phase: load result
    logic trialOn;   // comparison phase: drive trial code out
  } seqStrobe_t;

endpackage

// File: rtl/adcSeqCtrl.sv
module adcSeqCtrl
  import adcSeqPkg::*;
#(
  parameter int NBITS       = 10,
  parameter int FIELD_W     = 2,
  parameter int CNT_W       = 10,
  parameter int BASE_SAMPLE = 60,
  parameter int BASE_BIT    = 12,
  parameter int BASE_EXTRA  = 14,
  parameter int ALT_SAMPLE  = 70,
  parameter int ALT_BIT     = 14,
  parameter int ALT_EXTRA   = 8,
  localparam int CFG_W      = 2 * FIELD_W,
  localparam int IDX_W      = $clog2(NBITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             startIn,
  input  logic [CFG_W-1:0] cfgIn,
  output seqStrobe_t       strobe,
  output logic             busy,
  output logic             sampleEn,
  output logic             done
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(NBITS - 1);
  localparam logic [CFG_W-1:0] ALT_CFG = {FIELD_W'(0), FIELD_W'(1)};

  seqState_t        state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] bitIdx;
  logic [CFG_W-1:0] cfgQ;
  logic             startOk;
  logic             cntZero;

  function automatic logic [CNT_W-1:0] sampleLen(input logic [CFG_W-1:0] c);
    if (c == ALT_CFG) return CNT_W'(ALT_SAMPLE);
    return CNT_W'(BASE_SAMPLE) << c[FIELD_W-1:0];
  endfunction

  function automatic logic [CNT_W-1:0] bitLen(input logic [CFG_W-1:0] c);
    if (c == ALT_CFG) return CNT_W'(ALT_BIT);
    return CNT_W'(BASE_BIT) << c[CFG_W-1:FIELD_W];
  endfunction

  function automatic logic [CNT_W-1:0] extraLen(input logic [CFG_W-1:0] c);
    if (c == ALT_CFG) return CNT_W'(ALT_EXTRA);
    return CNT_W'(BASE_EXTRA);
  endfunction

  assign startOk = (state == ST_IDLE) && startIn;
  assign cntZero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
      cfgQ   <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (startIn) begin
            cfgQ  <= cfgIn;
            cnt   <= sampleLen(cfgIn) - CNT_ONE;
            state <= ST_SAMPLE;
          end
        end
        ST_SAMPLE: begin
          if (cntZero) begin
            cnt    <= bitLen(cfgQ) - CNT_ONE;
            bitIdx <= IDX_TOP;
            state  <= ST_COMPARE;
          end else begin
            cnt <= cnt - CNT_ONE;
          end
        end
        ST_COMPARE: begin
          if (cntZero) begin
            if (bitIdx == '0) begin
              cnt   <= extraLen(cfgQ) - CNT_ONE;
              state <= ST_EXTRA;
            end else begin
              bitIdx <= bitIdx - IDX_ONE;
              cnt    <= bitLen(cfgQ) - CNT_ONE;
            end
          end else begin
            cnt <= cnt - CNT_ONE;
          end
        end
        ST_EXTRA: begin
          if (cntZero) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            cnt <= cnt - CNT_ONE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.clearSar = startOk;
    strobe.decide   = (state == ST_COMPARE) && cntZero;
    strobe.commit   = (state == ST_EXTRA) && cntZero;
    strobe.trialOn  = (state == ST_COMPARE);
  end

  assign busy     = (state != ST_IDLE);
  assign sampleEn = (state == ST_SAMPLE);

  // R8: done is a single-cycle pulse
  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: done coincides with the fall of busy
  p_done_at_end_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R7: latched setting is frozen while a conversion runs
  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(cfgQ));

  // R10: sample enable only inside a busy period
  p_sample_busy_r10: assert property (@(posedge clk) disable iff (rst)
    sampleEn |-> busy);

  // R3: busy only rises after an accepted start
  p_busy_from_start_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(startIn));

endmodule

// File: rtl/adcSeqData.sv
module adcSeqData
  import adcSeqPkg::*;
#(
  parameter int NBITS = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  seqStrobe_t       strobe,
  input  logic             compIn,
  output logic [NBITS-1:0] trialCode,
  output logic [NBITS-1:0] result
);

  localparam logic [NBITS-1:0] MSB_MASK = {1'b1, {(NBITS-1){1'b0}}};

  logic [NBITS-1:0] sar;   // decided bits so far
  logic [NBITS-1:0] mask;  // bit under test

  always_ff @(posedge clk) begin
    if (rst) begin
      sar    <= '0;
      mask   <= '0;
      result <= '0;
    end else begin
      if (strobe.clearSar) begin
        sar  <= '0;
        mask <= MSB_MASK;
      end else if (strobe.decide) begin
        if (compIn) sar <= sar | mask;
        mask <= mask >> 1;
      end
      if (strobe.commit) result <= sar;
    end
  end

  assign trialCode = strobe.trialOn ? (sar | mask) : '0;

  // R5: at most one bit under test at a time
  p_mask_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mask));

  // R5: all ten trials are finished before the result is committed
  p_trials_done_r5: assert property (@(posedge clk) disable iff (rst)
    strobe.commit |-> (mask == '0));

  // R9: result only moves on a commit
  p_result_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !strobe.commit |=> $stable(result));

  // R5: a trial always exposes one undecided bit
  p_trial_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
    strobe.trialOn |-> (trialCode != '0));

endmodule

// File: rtl/adcSeq.sv
module adcSeq
  import adcSeqPkg::*;
#(
  parameter int NBITS       = 10,
  parameter int FIELD_W     = 2,
  parameter int CNT_W       = 10,
  parameter int BASE_SAMPLE = 60,
  parameter int BASE_BIT    = 12,
  parameter int BASE_EXTRA  = 14,
  parameter int ALT_SAMPLE  = 70,
  parameter int ALT_BIT     = 14,
  parameter int ALT_EXTRA   = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 startIn,
  input  logic [2*FIELD_W-1:0] cfgIn,
  input  logic                 compIn,
  output logic                 sampleEn,
  output logic [NBITS-1:0]     trialCode,
  output logic                 busy,
  output logic [NBITS-1:0]     result,
  output logic                 done
);

  seqStrobe_t strobe;

  adcSeqCtrl #(
    .NBITS(NBITS), .FIELD_W(FIELD_W), .CNT_W(CNT_W),
    .BASE_SAMPLE(BASE_SAMPLE), .BASE_BIT(BASE_BIT), .BASE_EXTRA(BASE_EXTRA),
    .ALT_SAMPLE(ALT_SAMPLE), .ALT_BIT(ALT_BIT), .ALT_EXTRA(ALT_EXTRA)
  ) uCtrl (
    .clk(clk), .rst(rst), .startIn(startIn), .cfgIn(cfgIn),
    .strobe(strobe), .busy(busy), .sampleEn(sampleEn), .done(done)
  );

  adcSeqData #(.NBITS(NBITS)) uData (
    .clk(clk), .rst(rst), .strobe(strobe), .compIn(compIn),
    .trialCode(trialCode), .result(result)
  );

endmodule

// File: tb/adcSeq_test.sv
module adcSeq_test;

  logic       clk = 1'b0;
  logic       rst;
  logic       startIn;
  logic [3:0] cfgIn;
  logic       compIn;
  logic       sampleEn;
  logic [9:0] trialCode;
  logic       busy;
  logic [9:0] result;
  logic       done;
  logic [9:0] vin;
  logic [9:0] prevRes;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  // Ideal comparator
  assign compIn = (trialCode <= vin);

  adcSeq uut (
    .clk(clk), .rst(rst), .startIn(startIn), .cfgIn(cfgIn), .compIn(compIn),
    .sampleEn(sampleEn), .trialCode(trialCode), .busy(busy),
    .result(result), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expSample(input logic [3:0] c);
    if (c == 4'b0001) return 70;
    return 60 << c[1:0];
  endfunction

  function automatic int expBit(input logic [3:0] c);
    if (c == 4'b0001) return 14;
    return 12 << c[3:2];
  endfunction

  function automatic int expExtra(input logic [3:0] c);
    if (c == 4'b0001) return 8;
    return 14;
  endfunction

  task automatic runConv(input logic [3:0] c, input logic [9:0] v, input bit poke);
    int total = 0, smp = 0, cmp = 0;
    int firstTrial = 0;
    bit seen = 0, heldOk = 1, idleSample = 0;
    int expTotal;
    string rq;
    rq = (c == 4'b0001) ? "R4" : "R2";
    vin = v;
    @(negedge clk);
    startIn = 1'b1;
    cfgIn   = c;
    @(negedge clk);
    startIn = 1'b0;
    cfgIn   = ~c;  // R7: later cfg changes must not matter
    while (1) begin
      if (busy) total++;
      if (sampleEn) smp++;
      if (sampleEn && !busy) idleSample = 1;
      if (trialCode != 0) cmp++;
      if (!seen && trialCode != 0) begin
        firstTrial = int'(trialCode);
        seen = 1;
      end
      if (!done && result != prevRes) heldOk = 0;
      if (done) break;
      if (poke && total == 5) begin
        startIn = 1'b1;  // R7: start during busy is ignored
        cfgIn   = 4'b1111;
      end else begin
        startIn = 1'b0;
      end
      @(negedge clk);
    end
    startIn = 1'b0;
    expTotal = expSample(c) + 10 * expBit(c) + expExtra(c);
    check(smp == expSample(c), {rq, " sample length"}, smp, expSample(c));
    check(cmp == 10 * expBit(c), {rq, " compare length"}, cmp, 10 * expBit(c));
    check(total - smp - cmp == expExtra(c), {rq, " extra length"},
          total - smp - cmp, expExtra(c));
    check(total == expTotal, poke ? "R7 total under restart" : "R3 total busy",
          total, expTotal);
    check(firstTrial == 10'h200, "R5 first trial MSB", firstTrial, 10'h200);
    check(result == v, poke ? "R7 result under restart" : "R6 result",
          int'(result), int'(v));
    check(!busy, "R8 busy low at done", int'(busy), 0);
    check(heldOk, "R9 result held", int'(heldOk), 1);
    check(!idleSample, "R10 sampleEn inside busy", int'(idleSample), 0);
    @(negedge clk);
    check(!done, "R8 done one cycle", int'(done), 0);
    check(result == v, "R8 result stays after done", int'(result), int'(v));
    prevRes = v;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1;
    startIn = 1'b0;
    cfgIn = 4'b0000;
    vin = 10'h000;
    prevRes = 10'h000;
    repeat (3) @(negedge clk);
    check(!busy && !sampleEn && !done, "R1 controls in reset",
          int'({busy, sampleEn, done}), 0);
    check(trialCode == 0 && result == 0, "R1 data in reset",
          int'(trialCode | result), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !sampleEn && !done && result == 0, "R1 after release",
          int'({busy, sampleEn, done}), 0);

    // R2/R3/R4: sweep every setting with varied inputs
    for (int c = 0; c < 16; c++) begin
      logic [9:0] v;
      v = 10'((c * 10'h137 + 10'h0AB) ^ (c << 6));
      if (c == 0) v = 10'h000;
      if (c == 1) v = 10'h3FF;
      if (c == 2) v = 10'h200;
      if (c == 3) v = 10'h1FF;
      runConv(4'(c), v, 1'b0);
      repeat (c % 3) @(negedge clk);
    end

    // R6: alternating-bit patterns, fast setting
    runConv(4'b0000, 10'h2AA, 1'b0);
    runConv(4'b0000, 10'h155, 1'b0);
    runConv(4'b0000, 10'h001, 1'b0);

    // R7: restart attempts in the middle of conversions
    runConv(4'b0000, 10'h321, 1'b1);
    runConv(4'b0001, 10'h0F0, 1'b1);

    // R9: idle result holds
    repeat (20) @(negedge clk);
    check(result == prevRes && !busy, "R9 idle hold", int'(result), int'(prevRes));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule